// File: doc/BRIEF.md
# Double-Rate Serial Word Framer with CRC-5 Terminator

This block frames 16-bit words for a two-wire serial mode in which the data line carries a new bit on every edge of the serial clock, rising and falling alike. The transmit side takes words from a parallel handshake and turns each one into a 20-bit frame. A frame holds a two-bit lead-in, the sixteen data bits sent most significant first, and two interleaved parity bits. When the word flagged as last has gone out, the transmitter appends a 13-bit closing word. That word carries a fixed marker and a five-bit CRC computed over every data word of the message, the leading command word included.

The receive side parses the bit stream that comes back from a responding device during a read. It strips the lead-in and hands each word out with a one-cycle strobe. It checks the parity of every word and folds the word into its own CRC. When the closing word arrives, it compares that CRC with the transmitted value. Two situations are recognised from the lead-in of a word. If nothing answers the command, the first lead-in reads high-high. If the controller wants to stop a read early, it asks the receiver to pull the line low during the second lead-in bit of a later word, and the receiver then reports the read as aborted.

Inside the block, one serial bit corresponds to one system clock cycle. The serial clock output toggles once per bit, so every bit boundary is an edge of that clock.

Top module: `ddr_word_framer`

## Requirements
- R1: Each transmitted word is 20 serial bits in this order. First comes a two-bit lead-in: `01` for a command word (`tx_cmd`=1) and `11` for a data word. Next come data bits 15 down to 0. Last come the two parity bits.
- R2: The first parity bit is the XOR of data bits 15,13,…,1. The second parity bit is the inverse of the XOR of data bits 14,12,…,0.
- R3: For a command word, the transmitter replaces data bit 0 with the XOR of bits 14,12,…,2. This makes the second parity bit of the command word always 1. The replaced word is what is sent and what enters the CRC.
- R4: `tx_sck` toggles exactly once for every serial bit presented on `tx_sda`. While nothing is being sent, `tx_sck` holds its level, `tx_sda` is 1 and `tx_oe` is 0.
- R5: After the word sent with `tx_last`=1, the transmitter sends 13 closing bits in this order: `0`, `1`, `1100`, the five CRC bits from most significant to least, then `1`, `1`. `tx_oe` is 1 for every bit except the final closing `1`, during which it is 0.
- R6: The CRC uses the polynomial x^5+x^2+1 and starts at all ones. It shifts in the 16 data bits of every word, most significant first. It excludes lead-in, parity and closing bits. It restarts at all ones for each new message, on both the transmit and the receive side. On receive, the CRC is seeded by folding `rx_cmd_word` in when `rx_start` is asserted.
- R7: A received data word is presented on `rx_data`, with `rx_valid` high for one cycle, in the cycle after the clock edge that samples its last parity bit.
- R8: `parity_err` pulses together with `rx_valid` when the received parity bits differ from the R2 rule, and stays low otherwise.
- R9: If the first lead-in after `rx_start` reads `11`, `no_resp` pulses once. No word is delivered, and further bits are ignored until the next `rx_start`. A first lead-in of `10` is an acknowledge and is followed by data.
- R10: On any word after the first, while `abort_req` is 1, `rx_pull_low` is asserted during the second lead-in bit. A received lead-in of `10` on such a word makes `rx_aborted` pulse, and no word is delivered for it.
- R11: A lead-in of `01` starts the closing word. When its last bit is sampled, `rx_end` pulses. `crc_err` pulses if the received CRC differs from the running CRC. `frame_err` pulses if the marker is not `1100` or the two tail bits are not both 1.
- R12: While `rst` is high and just after it, `tx_ready`=1, `tx_sck`=0, `tx_sda`=1 and `tx_oe`=0, and every receive strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_word | input | 16 | Word to transmit |
| tx_cmd | input | 1 | Offered word is the command word |
| tx_last | input | 1 | Offered word is the last of the message |
| tx_ready | output | 1 | Transmitter can take a word |
| tx_sck | output | 1 | Serial clock, toggles per bit |
| tx_sda | output | 1 | Serial data out |
| tx_oe | output | 1 | Data line actively driven |
| rx_start | input | 1 | Begin a receive message |
| rx_cmd_word | input | 16 | Command word used to seed the receive CRC |
| rx_bit_valid | input | 1 | A serial bit is present on rx_sda |
| rx_sda | input | 1 | Serial data in (wired line value) |
| abort_req | input | 1 | Controller wants the current read stopped |
| rx_pull_low | output | 1 | Drive the line low now (abort request) |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 16 | Received word |
| parity_err | output | 1 | Parity mismatch strobe |
| crc_err | output | 1 | CRC mismatch strobe |
| frame_err | output | 1 | Bad lead-in, marker or tail strobe |
| no_resp | output | 1 | No device answered |
| rx_aborted | output | 1 | Read stopped by abort |
| rx_end | output | 1 | Closing word received |

## Verification
Some properties are checked on every cycle by assertions. Error strobes never last two cycles. The three outcome strobes (no answer, abort, end) are mutually exclusive. A no-answer outcome never delivers a word. The pull-low output appears only under an abort request. The serial clock toggles on every cycle inside a word, and the closing word begins with a driven zero.

Other behaviour can only be shown by the bench scenarios. These cover the exact bit order, the parity and CRC values, the forced spare bit in command words, and the detection of corrupted parity, CRC and marker. They also cover the silent-device and abort paths.

// File: rtl/ddr_frame_pkg.sv
package ddr_frame_pkg;

    localparam int WORD_W    = 16;
    localparam int PRE_W     = 2;
    localparam int PAR_W     = 2;
    localparam int FRAME_W   = PRE_W + WORD_W + PAR_W;
    localparam int CRC_W     = 5;
    localparam int MARK_W    = 4;
    localparam int TAIL_W    = 2;
    localparam int TERM_W    = PRE_W + MARK_W + CRC_W + TAIL_W;
    localparam int BODY_W    = WORD_W + PAR_W;
    localparam int TBODY_W   = TERM_W - PRE_W;
    localparam int CNT_W     = $clog2(FRAME_W);

    localparam logic [CRC_W-1:0]  CRC_INIT  = '1;
    localparam logic [CRC_W-1:0]  CRC_POLY  = 5'b00101;
    localparam logic [MARK_W-1:0] TERM_MARK = 4'b1100;
    localparam logic [PRE_W-1:0]  LEAD_DATA = 2'b11;
    localparam logic [PRE_W-1:0]  LEAD_CMD  = 2'b01;
    localparam logic [PRE_W-1:0]  LEAD_TERM = 2'b01;
    localparam logic [PRE_W-1:0]  LEAD_ACK  = 2'b10;

    typedef enum logic [1:0] {TX_IDLE, TX_WORD, TX_TERM} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_PRE, RX_BODY, RX_TERM} rx_state_t;

    typedef struct packed {
        logic [PRE_W-1:0]  lead;
        logic [WORD_W-1:0] data;
        logic [PAR_W-1:0]  par;
    } tx_frame_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [PAR_W-1:0]  par;
    } rx_body_t;

    typedef struct packed {
        logic [MARK_W-1:0] mark;
        logic [CRC_W-1:0]  crc;
        logic [TAIL_W-1:0] tail;
    } rx_close_t;

    function automatic logic [PAR_W-1:0] word_parity(input logic [WORD_W-1:0] w);
        logic p_odd;
        logic p_even;
        p_odd  = 1'b0;
        p_even = 1'b1;
        for (int i = 0; i < WORD_W; i += 2) begin
            p_even ^= w[i];
            p_odd  ^= w[i+1];
        end
        return {p_odd, p_even};
    endfunction

    function automatic logic [WORD_W-1:0] cmd_fix(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        logic s;
        s = 1'b0;
        for (int i = 2; i < WORD_W; i += 2) s ^= w[i];
        r    = w;
        r[0] = s;
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                  input logic [WORD_W-1:0] w);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ w[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/ddr_word_tx.sv
module ddr_word_tx
    import ddr_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_cmd,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              tx_sck,
    output logic              tx_sda,
    output logic              tx_oe
);

    localparam logic [CNT_W-1:0] WORD_END = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] TERM_END = CNT_W'(TERM_W - 1);

    tx_state_t          state;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               last_q;
    logic               sck_q;
    logic [CRC_W-1:0]   crc_q;
    logic [WORD_W-1:0]  word_adj;
    tx_frame_t          frame;
    logic [TERM_W-1:0]  close_bits;

    always_comb begin
        word_adj   = tx_cmd ? cmd_fix(tx_word) : tx_word;
        frame.lead = tx_cmd ? LEAD_CMD : LEAD_DATA;
        frame.data = word_adj;
        frame.par  = word_parity(word_adj);
        close_bits = {LEAD_TERM, TERM_MARK, crc_q, {TAIL_W{1'b1}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '0;
            cnt    <= '0;
            last_q <= 1'b0;
            sck_q  <= 1'b0;
            crc_q  <= CRC_INIT;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (tx_valid) begin
                        shreg  <= frame;
                        crc_q  <= crc_word(crc_q, word_adj);
                        last_q <= tx_last;
                        cnt    <= '0;
                        sck_q  <= ~sck_q;
                        state  <= TX_WORD;
                    end
                end
                TX_WORD: begin
                    if (cnt == WORD_END) begin
                        cnt <= '0;
                        if (last_q) begin
                            shreg <= {close_bits, {(FRAME_W-TERM_W){1'b0}}};
                            crc_q <= CRC_INIT;
                            sck_q <= ~sck_q;
                            state <= TX_TERM;
                        end else begin
                            state <= TX_IDLE;
                        end
                    end else begin
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                        sck_q <= ~sck_q;
                    end
                end
                TX_TERM: begin
                    if (cnt == TERM_END) begin
                        cnt   <= '0;
                        state <= TX_IDLE;
                    end else begin
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                        sck_q <= ~sck_q;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign tx_ready = (state == TX_IDLE);
    assign tx_sck   = sck_q;
    assign tx_sda   = (state == TX_IDLE) ? 1'b1 : shreg[FRAME_W-1];
    assign tx_oe    = (state == TX_WORD) || (state == TX_TERM && cnt != TERM_END);

    // R4: inside a word every cycle brings a new bit and a clock edge
    assert_sck_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (state == TX_WORD && cnt != WORD_END) |=> (tx_sck != $past(tx_sck)));

    // R5: the closing word opens with a driven zero
    assert_close_lead_R5: assert property (@(posedge clk) disable iff (rst)
        (state == TX_WORD && cnt == WORD_END && last_q) |=> (!tx_sda && tx_oe));

    // R4: an idle line is released high
    assert_idle_line_R4: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (tx_sda && !tx_oe));

endmodule

// File: rtl/ddr_word_rx.sv
module ddr_word_rx
    import ddr_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic [WORD_W-1:0] rx_cmd_word,
    input  logic              rx_bit_valid,
    input  logic              rx_sda,
    input  logic              abort_req,
    output logic              rx_pull_low,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic              parity_err,
    output logic              crc_err,
    output logic              frame_err,
    output logic              no_resp,
    output logic              rx_aborted,
    output logic              rx_end
);

    localparam logic [CNT_W-1:0] BODY_END  = CNT_W'(BODY_W - 1);
    localparam logic [CNT_W-1:0] CLOSE_END = CNT_W'(TBODY_W - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic              lead0;
    logic              first;
    logic [BODY_W-1:0] sh;
    logic [CRC_W-1:0]  crc_q;
    rx_body_t          body;
    rx_close_t         close_w;

    always_comb begin
        body    = rx_body_t'({sh[BODY_W-2:0], rx_sda});
        close_w = rx_close_t'({sh[TBODY_W-2:0], rx_sda});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            cnt        <= '0;
            lead0      <= 1'b0;
            first      <= 1'b0;
            sh         <= '0;
            crc_q      <= CRC_INIT;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            parity_err <= 1'b0;
            crc_err    <= 1'b0;
            frame_err  <= 1'b0;
            no_resp    <= 1'b0;
            rx_aborted <= 1'b0;
            rx_end     <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            crc_err    <= 1'b0;
            frame_err  <= 1'b0;
            no_resp    <= 1'b0;
            rx_aborted <= 1'b0;
            rx_end     <= 1'b0;
            if (rx_start) begin
                state <= RX_PRE;
                cnt   <= '0;
                first <= 1'b1;
                crc_q <= crc_word(CRC_INIT, rx_cmd_word);
            end else if (rx_bit_valid) begin
                case (state)
                    RX_PRE: begin
                        if (cnt == '0) begin
                            lead0 <= rx_sda;
                            cnt   <= CNT_W'(1);
                        end else begin
                            cnt <= '0;
                            if ({lead0, rx_sda} == LEAD_TERM) begin
                                state <= RX_TERM;
                            end else if (first && {lead0, rx_sda} == LEAD_DATA) begin
                                no_resp <= 1'b1;
                                state   <= RX_IDLE;
                            end else if (!first && {lead0, rx_sda} == LEAD_ACK) begin
                                rx_aborted <= 1'b1;
                                state      <= RX_IDLE;
                            end else if ({lead0, rx_sda} == 2'b00) begin
                                frame_err <= 1'b1;
                                state     <= RX_IDLE;
                            end else begin
                                first <= 1'b0;
                                state <= RX_BODY;
                            end
                        end
                    end
                    RX_BODY: begin
                        if (cnt == BODY_END) begin
                            cnt        <= '0;
                            rx_valid   <= 1'b1;
                            rx_data    <= body.data;
                            parity_err <= (body.par != word_parity(body.data));
                            crc_q      <= crc_word(crc_q, body.data);
                            state      <= RX_PRE;
                        end else begin
                            sh  <= {sh[BODY_W-2:0], rx_sda};
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_TERM: begin
                        if (cnt == CLOSE_END) begin
                            cnt       <= '0;
                            rx_end    <= 1'b1;
                            crc_err   <= (close_w.crc != crc_q);
                            frame_err <= (close_w.mark != TERM_MARK) || (close_w.tail != '1);
                            state     <= RX_IDLE;
                        end else begin
                            sh  <= {sh[BODY_W-2:0], rx_sda};
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rx_pull_low = abort_req && (state == RX_PRE) && (cnt != '0) && !first;

    // R8: parity error is a single-cycle strobe
    assert_par_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        parity_err |=> !parity_err);

    // R11: CRC error is a single-cycle strobe
    assert_crc_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> !crc_err);

    // R10: the line is only pulled under an abort request
    assert_pull_gate_R10: assert property (@(posedge clk) disable iff (rst)
        rx_pull_low |-> abort_req);

    // R9: outcome strobes exclude each other, and a silent device yields no word
    assert_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({no_resp, rx_aborted, rx_end}) && !(no_resp && rx_valid));

endmodule

// File: rtl/ddr_word_framer.sv
module ddr_word_framer
    import ddr_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_cmd,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              tx_sck,
    output logic              tx_sda,
    output logic              tx_oe,
    input  logic              rx_start,
    input  logic [WORD_W-1:0] rx_cmd_word,
    input  logic              rx_bit_valid,
    input  logic              rx_sda,
    input  logic              abort_req,
    output logic              rx_pull_low,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic              parity_err,
    output logic              crc_err,
    output logic              frame_err,
    output logic              no_resp,
    output logic              rx_aborted,
    output logic              rx_end
);

    ddr_word_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_valid (tx_valid),
        .tx_word  (tx_word),
        .tx_cmd   (tx_cmd),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .tx_sck   (tx_sck),
        .tx_sda   (tx_sda),
        .tx_oe    (tx_oe)
    );

    ddr_word_rx u_rx (
        .clk          (clk),
        .rst          (rst),
        .rx_start     (rx_start),
        .rx_cmd_word  (rx_cmd_word),
        .rx_bit_valid (rx_bit_valid),
        .rx_sda       (rx_sda),
        .abort_req    (abort_req),
        .rx_pull_low  (rx_pull_low),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .parity_err   (parity_err),
        .crc_err      (crc_err),
        .frame_err    (frame_err),
        .no_resp      (no_resp),
        .rx_aborted   (rx_aborted),
        .rx_end       (rx_end)
    );

endmodule

// File: tb/ddr_word_framer_bench.sv
module ddr_word_framer_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0, tx_cmd = 1'b0, tx_last = 1'b0;
    logic [15:0] tx_word = '0;
    logic tx_ready, tx_sck, tx_sda, tx_oe;
    logic rx_start = 1'b0, rx_bit_valid = 1'b0, rx_bit = 1'b1, abort_req = 1'b0;
    logic [15:0] rx_cmd_word = '0;
    logic rx_line, rx_pull_low, rx_valid, parity_err, crc_err, frame_err, no_resp, rx_aborted, rx_end;
    logic [15:0] rx_data;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign rx_line = rx_bit & ~rx_pull_low;

    ddr_word_framer u_ddr_word_framer (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_word(tx_word), .tx_cmd(tx_cmd),
        .tx_last(tx_last), .tx_ready(tx_ready), .tx_sck(tx_sck), .tx_sda(tx_sda), .tx_oe(tx_oe),
        .rx_start(rx_start), .rx_cmd_word(rx_cmd_word), .rx_bit_valid(rx_bit_valid),
        .rx_sda(rx_line), .abort_req(abort_req), .rx_pull_low(rx_pull_low), .rx_valid(rx_valid),
        .rx_data(rx_data), .parity_err(parity_err), .crc_err(crc_err), .frame_err(frame_err),
        .no_resp(no_resp), .rx_aborted(rx_aborted), .rx_end(rx_end)
    );

    // ---------------- reference functions ----------------
    function automatic logic [1:0] ref_par(input logic [15:0] w);
        logic a, b;
        a = w[15]^w[13]^w[11]^w[9]^w[7]^w[5]^w[3]^w[1];
        b = ~(w[14]^w[12]^w[10]^w[8]^w[6]^w[4]^w[2]^w[0]);
        return {a, b};
    endfunction

    function automatic logic [15:0] ref_fix(input logic [15:0] w);
        logic [15:0] r;
        r = w;
        r[0] = w[14]^w[12]^w[10]^w[8]^w[6]^w[4]^w[2];
        return r;
    endfunction

    function automatic logic [4:0] ref_crc(input logic [4:0] c, input logic [15:0] w);
        logic [4:0] r;
        logic f;
        r = c;
        for (int i = 15; i >= 0; i--) begin
            f = r[4] ^ w[i];
            r = {r[3:0], 1'b0};
            if (f) r = r ^ 5'b00101;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- tx capture ----------------
    logic cap_en = 1'b0;
    logic prev_sck = 1'b0;
    logic capd [0:255];
    logic capoe [0:255];
    int capn = 0;
    always @(negedge clk) begin
        if (cap_en && tx_sck != prev_sck && capn < 256) begin
            capd[capn]  = tx_sda;
            capoe[capn] = tx_oe;
            capn++;
        end
        prev_sck = tx_sck;
    end

    logic expd [0:255];
    int expn;
    task automatic put(input logic b);
        expd[expn] = b;
        expn++;
    endtask

    task automatic tx_message(input int nw, input logic [15:0] cmdw);
        logic [15:0] words [0:7];
        logic [15:0] w;
        logic [4:0] crc;
        int mism;
        int fidx;
        words[0] = cmdw;
        for (int i = 1; i < nw; i++) words[i] = 16'($urandom);
        expn = 0;
        crc = 5'h1F;
        for (int i = 0; i < nw; i++) begin
            w = (i == 0) ? ref_fix(words[i]) : words[i];
            crc = ref_crc(crc, w);
            put(i != 0); put(1'b1);
            for (int b = 15; b >= 0; b--) put(w[b]);
            put(ref_par(w)[1]); put(ref_par(w)[0]);
        end
        put(1'b0); put(1'b1); put(1'b1); put(1'b1); put(1'b0); put(1'b0);
        for (int b = 4; b >= 0; b--) put(crc[b]);
        put(1'b1); put(1'b1);
        capn = 0;
        cap_en = 1'b1;
        for (int i = 0; i < nw; i++) begin
            while (!tx_ready) @(negedge clk);
            tx_valid = 1'b1; tx_word = words[i]; tx_cmd = (i == 0); tx_last = (i == nw - 1);
            @(negedge clk);
            tx_valid = 1'b0;
        end
        while (!tx_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        cap_en = 1'b0;
        check(capn == expn, "R1 R4 bit count", capn, expn);
        mism = 0; fidx = -1;
        for (int i = 0; i < expn && i < capn; i++)
            if (capd[i] !== expd[i]) begin mism++; if (fidx < 0) fidx = i; end
        check(mism == 0, "R1 R2 bit stream first-mismatch-index", fidx, -1);
        check(capn > 19 && capd[19] === 1'b1, "R3 command second parity", capn > 19 ? int'(capd[19]) : -1, 1);
        mism = 0;
        for (int i = expn - 7; i < expn - 2 && i < capn; i++) if (capd[i] !== expd[i]) mism++;
        check(mism == 0, "R6 crc field", mism, 0);
        mism = 0;
        for (int i = 0; i < capn; i++) if (capoe[i] !== (i != capn - 1)) mism++;
        check(mism == 0, "R5 drive enable", mism, 0);
        check(tx_sda === 1'b1 && tx_oe === 1'b0, "R4 idle line", {tx_sda, tx_oe}, 2);
    endtask

    // ---------------- rx monitor ----------------
    logic [15:0] got [0:15];
    int gotn = 0, n_par = 0, n_crc = 0, n_frm = 0, n_nr = 0, n_ab = 0, n_end = 0;
    always @(negedge clk) begin
        if (rx_valid && gotn < 16) begin got[gotn] = rx_data; gotn++; end
        n_par += int'(parity_err);
        n_crc += int'(crc_err);
        n_frm += int'(frame_err);
        n_nr  += int'(no_resp);
        n_ab  += int'(rx_aborted);
        n_end += int'(rx_end);
    end

    logic rxb [0:255];
    int rxn;
    task automatic rput(input logic b);
        rxb[rxn] = b;
        rxn++;
    endtask

    // kind: 0 good, 1 bad parity in word 1, 2 bad crc, 3 no answer, 4 abort, 5 bad marker
    task automatic rx_message(input int nw, input int kind);
        logic [15:0] cmdw, words [0:7];
        logic [4:0] crc;
        logic [1:0] p;
        cmdw = 16'($urandom);
        crc = ref_crc(5'h1F, cmdw);
        rxn = 0;
        for (int i = 0; i < nw; i++) begin
            words[i] = 16'($urandom);
            crc = ref_crc(crc, words[i]);
            if (i == 0) begin rput(1'b1); rput(kind == 3); end
            else begin rput(1'b1); rput(1'b1); end
            for (int b = 15; b >= 0; b--) rput(words[i][b]);
            p = ref_par(words[i]);
            if (kind == 1 && i == 0) p[0] = ~p[0];
            rput(p[1]); rput(p[0]);
        end
        if (kind == 2) crc = crc ^ 5'h04;
        rput(1'b0); rput(1'b1);
        rput(1'b1); rput(1'b1); rput(1'b0); rput(kind == 5);
        for (int b = 4; b >= 0; b--) rput(crc[b]);
        rput(1'b1); rput(1'b1);
        gotn = 0; n_par = 0; n_crc = 0; n_frm = 0; n_nr = 0; n_ab = 0; n_end = 0;
        abort_req = (kind == 4);
        rx_start = 1'b1; rx_cmd_word = cmdw;
        @(negedge clk);
        rx_start = 1'b0;
        for (int i = 0; i < rxn; i++) begin
            rx_bit_valid = 1'b1; rx_bit = rxb[i];
            @(negedge clk);
        end
        rx_bit_valid = 1'b0; rx_bit = 1'b1;
        repeat (3) @(negedge clk);
        abort_req = 1'b0;
        case (kind)
            0: begin
                check(gotn == nw, "R7 word count", gotn, nw);
                for (int i = 0; i < nw && i < gotn; i++)
                    check(got[i] == words[i], "R7 word value", got[i], words[i]);
                check(n_par == 0 && n_crc == 0 && n_frm == 0, "R8 R11 clean message", n_par + n_crc + n_frm, 0);
                check(n_end == 1, "R11 end strobe", n_end, 1);
            end
            1: check(n_par == 1, "R8 parity error", n_par, 1);
            2: begin
                check(n_crc == 1, "R11 crc error", n_crc, 1);
                check(n_par == 0, "R6 crc fault leaves parity clean", n_par, 0);
            end
            3: begin
                check(n_nr == 1, "R9 no responder", n_nr, 1);
                check(gotn == 0 && n_end == 0, "R9 later bits ignored", gotn + n_end, 0);
            end
            4: begin
                check(n_ab == 1, "R10 abort strobe", n_ab, 1);
                check(gotn == 1 && n_end == 0, "R10 only first word delivered", gotn, 1);
            end
            default: begin
                check(n_frm == 1, "R11 bad marker", n_frm, 1);
                check(n_crc == 0, "R11 crc still good", n_crc, 0);
            end
        endcase
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(tx_ready && !tx_sck && tx_sda && !tx_oe, "R12 tx in reset", {tx_ready, tx_sck, tx_sda, tx_oe}, 4'b1010);
        rst = 1'b0;
        @(negedge clk);
        check(tx_ready && !tx_sck && tx_sda && !tx_oe, "R12 tx after reset", {tx_ready, tx_sck, tx_sda, tx_oe}, 4'b1010);
        check(!(rx_valid | parity_err | crc_err | frame_err | no_resp | rx_aborted | rx_end | rx_pull_low),
              "R12 rx strobes idle", 0, 0);
        // directed corners: all-zero and all-one command words
        tx_message(1, 16'h0000);
        tx_message(2, 16'hFFFF);
        tx_message(2, 16'h5555);
        for (int k = 0; k < 6; k++) tx_message(1 + int'($urandom % 5), 16'($urandom));
        rx_message(1, 0);
        for (int k = 0; k < 5; k++) rx_message(1 + int'($urandom % 5), 0);
        rx_message(2, 1);
        rx_message(3, 2);
        rx_message(2, 3);
        rx_message(3, 4);
        rx_message(2, 5);
        rx_message(2, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule